// File: doc/BRIEF.md
# Banked XOR Window Address Translator

This block sits between an 8-bit CPU's 16-bit address bus and a 512 KB SRAM. It splits the CPU space into eight 8 KB regions, selected by the top three CPU address bits, and holds one 6-bit entry per region. The entry's upper three bits become the top three physical address lines and pick one of eight 64 KB banks. Its lower three bits are XORed with the CPU's top three address lines. The access can therefore land in any 8 KB block of the chosen bank. The thirteen offset bits reach the SRAM unchanged.

A controller rewrites entries through a small write port. Each write first goes into a staging copy, and the live table loads the staging copy only at a CPU cycle boundary, so an address never changes partway through a bus cycle. A protect input can mark regions as remappable. Any write that would point such a region at bank 0 is then refused and flagged, which keeps bank 0 free for system memory.

Top module: `xwin_translate`

## Requirements
- R1: `physAddr[18:16]` equals the bank field (`cfgData[5:3]` as written) of the live entry for region `cpuAddr[15:13]`.
- R2: `physAddr[15:13]` equals `cpuAddr[15:13]` XOR the mask field (`cfgData[2:0]` as written) of that live entry.
- R3: `physAddr[12:0]` equals `cpuAddr[12:0]` at all times.
- R4: After reset every entry is zero and `physAddr` equals `{3'b000, cpuAddr}`.
- R5: A write (`cfgWrEn` high, region `cfgIdx`) changes only the staging copy. It has no effect on `physAddr` until `cycleStart` is sampled high on a later clock edge, and it is live from that edge on.
- R6: A write sampled on the same edge as `cycleStart` is not part of that commit and goes live at the next `cycleStart`.
- R7: When `protectEn` is high, `remapFlags[cfgIdx]` is high and the bank field is 0, the write is discarded and `cfgErr` is high for the one cycle after the write edge.
- R8: `cfgErr` stays low after any write that is accepted: protect low, flag clear, or nonzero bank. `cfgErr` also stays low in any cycle without a write.
- R9: The entry never alters address bit 12. The upper 4 KB half of a region therefore reaches only odd 4 KB blocks, and the lower half only even ones.
- R10: `physAddr` changes only when `cpuAddr` changes or after an edge where `cycleStart` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cycleStart | input | 1 | Marks a CPU cycle boundary; the staged table becomes live |
| cfgWrEn | input | 1 | Entry write strobe |
| cfgIdx | input | 3 | Region whose entry is written |
| cfgData | input | 6 | New entry: bank in [5:3], XOR mask in [2:0] |
| protectEn | input | 1 | Enables bank-0 write protection |
| remapFlags | input | 8 | One bit per region that marks the region as remappable |
| physAddr | output | 19 | Translated SRAM address |
| cfgErr | output | 1 | One-cycle pulse after a refused write |

## Verification
The checker watches every cycle to confirm three things. The offset bits pass through unchanged. The translated address holds steady unless the CPU address moves or a commit edge has just passed. The error pulse follows exactly the writes that protection refuses. The bench scenarios are needed for the bank and XOR arithmetic, which they compare against a model table kept in the bench. The scenarios also show the delay between staging and commit, the write that lands on the same edge as a commit, the proof that a refused write left both tables untouched, and the odd and even 4 KB reach of a region's two halves.

// File: rtl/xwin_pkg.sv
package xwin_pkg;
  localparam int CPU_AW      = 16;
  localparam int REGION_BITS = 3;
  localparam int BANK_BITS   = 3;
  localparam int OFFS_BITS   = CPU_AW - REGION_BITS;
  localparam int PHYS_AW     = CPU_AW + BANK_BITS;
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam int MAP_W       = BANK_BITS + REGION_BITS;

  typedef struct packed {
    logic [BANK_BITS-1:0]   bank;
    logic [REGION_BITS-1:0] mask;
  } mapEntry_t;

  typedef struct packed {
    logic                   stageWr;
    logic [REGION_BITS-1:0] stageIdx;
    logic                   commit;
    logic                   reject;
  } ctrlStrobe_t;
endpackage

// File: rtl/xwin_ctrl.sv
module xwin_ctrl
  import xwin_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cycleStart,
  input  logic                   cfgWrEn,
  input  logic [REGION_BITS-1:0] cfgIdx,
  input  logic [BANK_BITS-1:0]   cfgBank,
  input  logic                   protectEn,
  input  logic [NUM_REGIONS-1:0] remapFlags,
  output ctrlStrobe_t            strobe,
  output logic                   cfgErr
);
  logic bankZero;
  logic refuse;
  logic errQ;

  always_comb begin
    bankZero        = (cfgBank == '0);
    refuse          = cfgWrEn && protectEn && remapFlags[cfgIdx] && bankZero;
    strobe.stageWr  = cfgWrEn && !refuse;
    strobe.stageIdx = cfgIdx;
    strobe.commit   = cycleStart;
    strobe.reject   = refuse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= strobe.reject;
  end

  assign cfgErr = errQ;
endmodule

// File: rtl/xwin_datapath.sv
module xwin_datapath
  import xwin_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [MAP_W-1:0]   wrData,
  input  logic [CPU_AW-1:0]  cpuAddr,
  output logic [PHYS_AW-1:0] physAddr
);
  mapEntry_t stageQ  [NUM_REGIONS];
  mapEntry_t activeQ [NUM_REGIONS];
  mapEntry_t wrEntry;
  mapEntry_t selEntry;
  logic [REGION_BITS-1:0] region;

  assign wrEntry = mapEntry_t'(wrData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        stageQ[r]  <= '0;
        activeQ[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (strobe.stageWr && (strobe.stageIdx == REGION_BITS'(r)))
          stageQ[r] <= wrEntry;
        if (strobe.commit)
          activeQ[r] <= stageQ[r];
      end
    end
  end

  always_comb begin
    region   = cpuAddr[CPU_AW-1 -: REGION_BITS];
    selEntry = activeQ[region];
    physAddr = {selEntry.bank, region ^ selEntry.mask, cpuAddr[OFFS_BITS-1:0]};
  end
endmodule

// File: rtl/xwin_translate.sv
module xwin_translate
  import xwin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic        cycleStart,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgIdx,
  input  logic [5:0]  cfgData,
  input  logic        protectEn,
  input  logic [7:0]  remapFlags,
  output logic [18:0] physAddr,
  output logic        cfgErr
);
  ctrlStrobe_t strobe;

  xwin_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .cfgWrEn    (cfgWrEn),
    .cfgIdx     (cfgIdx),
    .cfgBank    (cfgData[MAP_W-1 -: BANK_BITS]),
    .protectEn  (protectEn),
    .remapFlags (remapFlags),
    .strobe     (strobe),
    .cfgErr     (cfgErr)
  );

  xwin_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (cfgData),
    .cpuAddr  (cpuAddr),
    .physAddr (physAddr)
  );
endmodule

// File: rtl/xwin_translate_chk.sv
module xwin_translate_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cycleStart,
  input logic        cfgWrEn,
  input logic [2:0]  cfgIdx,
  input logic [5:0]  cfgData,
  input logic        protectEn,
  input logic [7:0]  remapFlags,
  input logic [18:0] physAddr,
  input logic        cfgErr
);
  logic refusable;
  assign refusable = cfgWrEn && protectEn && remapFlags[cfgIdx] && (cfgData[5:3] == 3'b000);

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[12:0] == cpuAddr[12:0]);

  assert_bit12_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[12] == cpuAddr[12]);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    refusable |=> cfgErr);

  assert_no_spurious_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    !refusable |=> !cfgErr);

  assert_hold_midcycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cycleStart) && $stable(cpuAddr)) |-> $stable(physAddr));
endmodule

bind xwin_translate xwin_translate_chk chk_i (.*);

// File: tb/xwin_translate_tb_top.sv
module xwin_translate_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cpuAddr;
  logic        cycleStart;
  logic        cfgWrEn;
  logic [2:0]  cfgIdx;
  logic [5:0]  cfgData;
  logic        protectEn;
  logic [7:0]  remapFlags;
  logic [18:0] physAddr;
  logic        cfgErr;

  int checks = 0;
  int errors = 0;
  logic [5:0] expTab [8];
  logic lastErr;

  always #4 clk = ~clk;

  xwin_translate dut_i (.*);

  function automatic logic [18:0] expPhys(input logic [15:0] a);
    logic [5:0] e;
    e = expTab[a[15:13]];
    return {e[5:3], a[15:13] ^ e[2:0], a[12:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    @(negedge clk);
    cpuAddr = a;
    #1;
    check(req, 32'(physAddr), 32'(expPhys(a)));
  endtask

  task automatic doWrite(input logic [2:0] idx, input logic [5:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
    lastErr = cfgErr;
  endtask

  task automatic commit();
    @(negedge clk);
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
  endtask

  task automatic testReset();
    for (int r = 0; r < 8; r++) expTab[r] = '0;
    probe("R4", 16'h0000);
    probe("R4", 16'hFFFF);
    probe("R4", 16'h9234);
    check("R4 err", 32'(cfgErr), 0);
  endtask

  task automatic testBankMask();
    doWrite(3'd4, 6'b101_011);
    commit();
    expTab[4] = 6'b101_011;
    @(negedge clk); cpuAddr = 16'h9234; #1;
    check("R1 R2 literal", 32'(physAddr), 32'h5F234);
    probe("R1", 16'h8001);
    doWrite(3'd0, 6'b111_111);
    doWrite(3'd7, 6'b010_001);
    commit();
    expTab[0] = 6'b111_111; expTab[7] = 6'b010_001;
    probe("R2", 16'h1ABC);
    probe("R2", 16'hE555);
    probe("R3", 16'h1FFF);
  endtask

  task automatic testCommitDelay();
    doWrite(3'd2, 6'b011_110);
    probe("R5 staged only", 16'h4321);
    probe("R5 staged only", 16'h5FFF);
    commit();
    expTab[2] = 6'b011_110;
    probe("R5 after commit", 16'h4321);
  endtask

  task automatic testSameEdge();
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = 3'd3; cfgData = 6'b110_010; cycleStart = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; cycleStart = 1'b0;
    probe("R6 not yet", 16'h6000);
    commit();
    expTab[3] = 6'b110_010;
    probe("R6 next commit", 16'h6000);
  endtask

  task automatic testProtect();
    @(negedge clk);
    protectEn = 1'b1; remapFlags = 8'b0001_0100;
    doWrite(3'd4, 6'b000_111);
    check("R7 err", 32'(lastErr), 1);
    @(negedge clk); #1;
    check("R7 one cycle", 32'(cfgErr), 0);
    commit();
    probe("R7 unchanged", 16'h8765);
    doWrite(3'd4, 6'b001_000);
    check("R8 nonzero bank", 32'(lastErr), 0);
    doWrite(3'd1, 6'b000_101);
    check("R8 flag clear", 32'(lastErr), 0);
    commit();
    expTab[4] = 6'b001_000; expTab[1] = 6'b000_101;
    probe("R8 accepted", 16'h8765);
    probe("R8 accepted", 16'h2345);
    @(negedge clk); protectEn = 1'b0;
    doWrite(3'd2, 6'b000_000);
    check("R8 protect off", 32'(lastErr), 0);
    commit();
    expTab[2] = 6'b000_000;
    probe("R8 protect off", 16'h4444);
  endtask

  task automatic testHalves();
    doWrite(3'd4, 6'b010_101);
    commit();
    expTab[4] = 6'b010_101;
    for (int m = 0; m < 8; m++) begin
      doWrite(3'd4, {3'b010, 3'(m)});
      commit();
      expTab[4] = {3'b010, 3'(m)};
      @(negedge clk); cpuAddr = 16'h9000; #1;
      check("R9 upper half odd", 32'(physAddr[12]), 1);
      @(negedge clk); cpuAddr = 16'h8000; #1;
      check("R9 lower half even", 32'(physAddr[12]), 0);
    end
    probe("R9", 16'h9ABC);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cpuAddr = '0; cycleStart = 1'b0; cfgWrEn = 1'b0;
    cfgIdx = '0; cfgData = '0; protectEn = 1'b0; remapFlags = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBankMask();
    testCommitDelay();
    testSameEdge();
    testProtect();
    testHalves();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule